// File: doc/BRIEF.md
# One-Position Word Shifter and Rotator

This unit moves a data word by exactly one bit position, or leaves it unchanged, under a three-bit operation code. Four codes perform a logical move toward the most significant end or toward the least significant end. In each direction the vacated end bit is either supplied from an external fill pin (a shift) or taken from the bit that falls off the opposite end (a rotate). The unit has no clock and no state. The result follows the inputs through combinational logic only.

Each output bit is picked by its own small selector. The candidates are the bit itself, the bit just below it, and the bit just above it. At the two ends of the word, the missing neighbour is replaced by the fill pin or by the wrap-around bit, as the code requires. The word width is a parameter, with a default of 4 bits. A wide datapath can use the block as a single-step barrel stage. A serial-style datapath can feed one bit per operation through the fill pins.

Top module: `shr_shift_rot`

## Requirements
- R1: With op_i[2:1] = 2'b00, data_o equals data_i, whatever op_i[0] is.
- R2: The spare codes 3'b010 and 3'b011 give data_o equal to data_i.
- R3: With op_i = 3'b100 (shift toward MSB), data_o = {data_i[W-2:0], fill_lsb_i}.
- R4: With op_i = 3'b101 (rotate toward MSB), data_o = {data_i[W-2:0], data_i[W-1]}.
- R5: With op_i = 3'b110 (shift toward LSB), data_o = {fill_msb_i, data_i[W-1:1]}.
- R6: With op_i = 3'b111 (rotate toward LSB), data_o = {data_i[0], data_i[W-1:1]}.
- R7: The fill pins have no effect on data_o for any code other than 3'b100 and 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | WIDTH | Word to be moved |
| op_i | input | 3 | Operation code |
| fill_msb_i | input | 1 | Bit entering at the top on a shift toward LSB |
| fill_lsb_i | input | 1 | Bit entering at bit 0 on a shift toward MSB |
| data_o | output | WIDTH | Moved word |

## Verification
The only internal state that can go wrong is the decoded move selection and the edge source, and both show at once in data_o. A wrong selection makes the whole word shifted, unshifted or moved the wrong way. This is visible in the same time step for almost any data value except all-zeros or all-ones. A wrong edge source, such as fill in place of wrap, corrupts only bit 0 or the top bit. It is exposed only when the fill pin and the wrapped bit differ, so the bench drives both fill values against every data word.

// File: rtl/shr_pkg.sv
package shr_pkg;
   // per-bit source selection produced by the operation decoder
   typedef enum logic [1:0] {
      MV_KEEP = 2'd0,  // bit keeps its own value
      MV_UP   = 2'd1,  // bit takes its lower neighbour (word moves toward MSB)
      MV_DN   = 2'd2,  // bit takes its upper neighbour (word moves toward LSB)
      MV_RSV  = 2'd3   // never produced; treated as keep
   } mv_e;

   localparam int unsigned OP_W = 3;
endpackage

// File: rtl/shr_op_decode.sv
module shr_op_decode
   import shr_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output mv_e             mv_o,
   output logic            wrap_o
);
   always_comb begin
      mv_o   = MV_KEEP;
      wrap_o = 1'b0;
      unique case (op_i)
         3'b100: begin mv_o = MV_UP; wrap_o = 1'b0; end
         3'b101: begin mv_o = MV_UP; wrap_o = 1'b1; end
         3'b110: begin mv_o = MV_DN; wrap_o = 1'b0; end
         3'b111: begin mv_o = MV_DN; wrap_o = 1'b1; end
         default: begin mv_o = MV_KEEP; wrap_o = 1'b0; end
      endcase
   end
endmodule

// File: rtl/shr_bit_sel.sv
module shr_bit_sel
   import shr_pkg::*;
(
   input  logic own_i,
   input  logic below_i,
   input  logic above_i,
   input  mv_e  mv_i,
   output logic bit_o
);
   always_comb begin
      case (mv_i)
         MV_UP:   bit_o = below_i;
         MV_DN:   bit_o = above_i;
         default: bit_o = own_i;
      endcase
   end
endmodule

// File: rtl/shr_edge_src.sv
module shr_edge_src (
   input  logic wrap_i,
   input  logic fill_i,
   input  logic far_bit_i,
   output logic edge_o
);
   assign edge_o = wrap_i ? far_bit_i : fill_i;
endmodule

// File: rtl/shr_shift_rot.sv
module shr_shift_rot
   import shr_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] data_i,
   input  logic [2:0]       op_i,
   input  logic             fill_msb_i,
   input  logic             fill_lsb_i,
   output logic [WIDTH-1:0] data_o
);
   localparam int unsigned TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("shr_shift_rot: WIDTH must be at least 2");
   end

   mv_e  mv;
   logic wrap;
   logic edge_lo;  // feeds bit 0 when the word moves toward MSB
   logic edge_hi;  // feeds the top bit when the word moves toward LSB

   shr_op_decode u_dec (
      .op_i   (op_i),
      .mv_o   (mv),
      .wrap_o (wrap)
   );

   shr_edge_src u_edge_lo (
      .wrap_i    (wrap),
      .fill_i    (fill_lsb_i),
      .far_bit_i (data_i[TOP]),
      .edge_o    (edge_lo)
   );

   shr_edge_src u_edge_hi (
      .wrap_i    (wrap),
      .fill_i    (fill_msb_i),
      .far_bit_i (data_i[0]),
      .edge_o    (edge_hi)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic below;
      logic above;
      if (i == 0) begin : g_lo_end
         assign below = edge_lo;
      end else begin : g_lo_mid
         assign below = data_i[i-1];
      end
      if (i == TOP) begin : g_hi_end
         assign above = edge_hi;
      end else begin : g_hi_mid
         assign above = data_i[i+1];
      end
      shr_bit_sel u_sel (
         .own_i   (data_i[i]),
         .below_i (below),
         .above_i (above),
         .mv_i    (mv),
         .bit_o   (data_o[i])
      );
   end
endmodule

// File: rtl/shr_shift_rot_chk.sv
module shr_shift_rot_chk #(
   parameter int unsigned WIDTH = 4
) (
   input logic [WIDTH-1:0] data_i,
   input logic [2:0]       op_i,
   input logic             fill_msb_i,
   input logic             fill_lsb_i,
   input logic [WIDTH-1:0] data_o
);
   always_comb begin
      if (!$isunknown({data_i, op_i, fill_msb_i, fill_lsb_i, data_o})) begin
         if (op_i[2:1] == 2'b00)
            a_r1_pass: assert (data_o == data_i);
         if (op_i[2:1] == 2'b01)
            a_r2_spare_pass: assert (data_o == data_i);
         if (op_i == 3'b100)
            a_r3_shl: assert (data_o == {data_i[WIDTH-2:0], fill_lsb_i});
         if (op_i == 3'b101)
            a_r4_rol: assert (data_o == {data_i[WIDTH-2:0], data_i[WIDTH-1]});
         if (op_i == 3'b110)
            a_r5_shr: assert (data_o == {fill_msb_i, data_i[WIDTH-1:1]});
         if (op_i == 3'b111)
            a_r6_ror: assert (data_o == {data_i[0], data_i[WIDTH-1:1]});
         if (op_i[2] && op_i[0])
            a_r7_rot_popcount: assert ($countones(data_o) == $countones(data_i));
      end
   end
endmodule

bind shr_shift_rot shr_shift_rot_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_shr_shift_rot.sv
module tb_shr_shift_rot;
   localparam int unsigned W = 4;

   logic         clk = 1'b0;
   logic [W-1:0] data_i;
   logic [2:0]   op_i;
   logic         fill_msb_i;
   logic         fill_lsb_i;
   logic [W-1:0] data_o;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   bit          done  = 1'b0;

   always #2.5 clk = ~clk;  // 200 MHz

   shr_shift_rot #(.WIDTH(W)) dut (
      .data_i(data_i), .op_i(op_i), .fill_msb_i(fill_msb_i),
      .fill_lsb_i(fill_lsb_i), .data_o(data_o)
   );

   function automatic logic [W-1:0] model(input logic [W-1:0] d, input logic [2:0] op,
                                          input logic fm, input logic fl);
      case (op)
         3'b100:  return {d[W-2:0], fl};       // R3
         3'b101:  return {d[W-2:0], d[W-1]};   // R4
         3'b110:  return {fm, d[W-1:1]};       // R5
         3'b111:  return {d[0], d[W-1:1]};     // R6
         default: return d;                    // R1, R2
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] op);
      case (op)
         3'b000, 3'b001: return "R1";
         3'b010, 3'b011: return "R2";
         3'b100: return "R3";
         3'b101: return "R4";
         3'b110: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic apply(input logic [W-1:0] d, input logic [2:0] op,
                        input logic fm, input logic fl, input string tag);
      logic [W-1:0] exp;
      @(posedge clk);
      data_i = d; op_i = op; fill_msb_i = fm; fill_lsb_i = fl;
      exp = model(d, op, fm, fl);
      @(negedge clk);
      n_vec++;
      if (data_o !== exp) begin
         n_bad++;
         $display("FAIL %s op=%b d=%b fm=%b fl=%b actual=%b expected=%b",
                  tag, op, d, fm, fl, data_o, exp);
      end
   endtask

   // R7: fill pins must not change the result of non-shift codes
   task automatic fill_indep(input logic [W-1:0] d, input logic [2:0] op);
      logic [W-1:0] first;
      @(posedge clk);
      data_i = d; op_i = op; fill_msb_i = 1'b0; fill_lsb_i = 1'b0;
      @(negedge clk);
      first = data_o;
      @(posedge clk);
      fill_msb_i = 1'b1; fill_lsb_i = 1'b1;
      @(negedge clk);
      n_vec++;
      if (data_o !== first) begin
         n_bad++;
         $display("FAIL R7 op=%b d=%b actual=%b expected=%b", op, d, data_o, first);
      end
   endtask

   initial begin
      data_i = '0; op_i = '0; fill_msb_i = 1'b0; fill_lsb_i = 1'b0;
      // directed corners: pass, edges differing from fill
      apply(4'b0000, 3'b000, 1'b1, 1'b1, "R1");
      apply(4'b1010, 3'b001, 1'b1, 1'b0, "R1");
      apply(4'b0110, 3'b010, 1'b1, 1'b1, "R2");
      apply(4'b1001, 3'b011, 1'b0, 1'b1, "R2");
      apply(4'b0111, 3'b100, 1'b0, 1'b1, "R3");
      apply(4'b1000, 3'b101, 1'b0, 1'b0, "R4");
      apply(4'b1110, 3'b110, 1'b1, 1'b0, "R5");
      apply(4'b0001, 3'b111, 1'b0, 1'b1, "R6");
      // exhaustive sweep
      for (int op = 0; op < 8; op++)
         for (int d = 0; d < (1 << W); d++)
            for (int f = 0; f < 4; f++)
               apply(d[W-1:0], op[2:0], f[1], f[0], req_of(op[2:0]));
      // fill independence on non-shift codes
      for (int op = 0; op < 8; op++)
         if (op != 4 && op != 6)
            for (int d = 0; d < (1 << W); d++)
               fill_indep(d[W-1:0], op[2:0]);
      // constrained random
      begin
         int unsigned seed = 32'h5EED_1234;
         logic [2:0] rop;
         seed = $urandom(seed);
         for (int k = 0; k < 300; k++) begin
            rop = $urandom_range(7, 0);
            apply($urandom_range((1 << W) - 1, 0), rop,
                  $urandom_range(1, 0), $urandom_range(1, 0), req_of(rop));
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule